// File: doc/BRIEF.md
# Integer 8x8 Forward DCT Tile Engine

This block turns one 8x8 tile of a single colour component plane into 64 frequency coefficients. A controller pulses `start` with the tile's top-left address and the plane's line pitch. The engine then reads the 64 bytes of the tile through a byte-wide read port with one cycle of read latency. It holds the samples as 21-bit zero-extended words, computes `T·X·Tᵀ` with one sequential multiply-accumulate unit, and scales the result down by 4096. The coefficients come out on a stream with a valid flag. A controller that walks a plane calls the engine once per tile. It finishes the luminance plane before the two chroma planes.

The transform matrix `T` is the orthonormal 8-point DCT basis scaled by 8√8 and rounded to integers. Row 0 is all 8. The other rows use the magnitudes 11, 10, 9, 8, 6, 4 and 2, with the usual cosine sign pattern. The entries are kept as 8-bit sign-magnitude constants. The product `T·X` is formed first and kept at full precision in an intermediate buffer. It is then multiplied by `Tᵀ`. A single arithmetic right shift by 12 is applied only to the final sum.

Top module: `fdct8_core`

## Requirements
- R1: After reset, and whenever no tile is in progress, `coef_valid`, `tile_done` and `mem_rd_en` are low.
- R2: After an accepted `start`, `mem_rd_en` is high for exactly 64 consecutive cycles. The n-th read (n = 0..63) uses address `tile_origin + (n/8)·img_width + (n%8)`, with `tile_origin` and `img_width` taken in the `start` cycle. Read data is expected on `mem_rdata` one cycle after its address.
- R3: Coefficient (u,v) equals `floor(Σ_j Σ_k T[u][k]·X[k][j]·T[v][j] / 4096)` before limiting. Here X[k][j] is the sample in tile row k, column j, and T[i][j] = round(8√8·c_i·cos((2j+1)iπ/16)), with c_0 = 1/√8 and c_i = 1/2 otherwise.
- R4: A tile whose 64 samples all equal value p yields DC = p and all 63 AC coefficients = 0.
- R5: Exactly 64 coefficients are produced, one per `coef_valid` cycle. They come out row-major: the m-th is (u = m/8, v = m%8), where u is the vertical frequency. `tile_done` is high for exactly one cycle, the cycle after the 64th coefficient.
- R6: `coef_data` carries DC (m = 0) as unsigned 0..255 and each AC as two's complement limited to −127..127. Values outside these ranges are clamped to the nearest bound.
- R7: A `start` that arrives while a tile is in progress is ignored. The address sequence and the coefficient stream of the running tile are unchanged.
- R8: The divide by 4096 rounds toward minus infinity, so negative non-integer results round down.
- R9: Samples are treated as unsigned, so a byte of 255 contributes +255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile (accepted only when idle) |
| tile_origin | input | ADDR_W | Address of the tile's top-left sample |
| img_width | input | WID_W | Plane line pitch in bytes |
| mem_rd_en | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| coef_valid | output | 1 | Coefficient strobe |
| coef_data | output | 8 | Coefficient value (DC unsigned, AC signed) |
| tile_done | output | 1 | One-cycle pulse after the last coefficient |

## Verification
The hardest thing to reach from the ports is the limiting path. With 8-bit unsigned input, the scaled AC values stay inside ±127, so the clamp can barely be provoked. The bench therefore drives the patterns that come closest to the bounds: a flat tile of 255 for the DC limit, and a hard vertical edge, which pushes coefficient (0,1) to its largest reachable magnitude. It checks every output against an independently computed model. Floor rounding of negative values is reached with an irregular tile placed at an unaligned origin, which gives many negative AC sums that are not multiples of 4096. A second `start` injected during both the fetch and the arithmetic phases exercises the ignore rule.

// File: rtl/fdct8_pkg.sv
`timescale 1ns/1ps
package fdct8_pkg;

  localparam int TILE_N   = 8;
  localparam int TILE_SQ  = TILE_N * TILE_N;
  localparam int IDX_W    = 3;
  localparam int ENTRY_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN,
    ST_ROWS,
    ST_COLS,
    ST_FIN
  } fdct8_state_e;

  // Scaled cosine entry T[u][x] as {sign, magnitude[6:0]}.
  // The angle is kept in units of pi/16 and folded into 0..8.
  function automatic logic [ENTRY_W-1:0] basis_entry(input int unsigned u,
                                                     input int unsigned x);
    int unsigned ang;
    logic        neg;
    logic [6:0]  mag;
    if (u == 0) return 8'd8;
    ang = ((2 * x + 1) * u) % 32;
    neg = 1'b0;
    if (ang > 16) ang = 32 - ang;
    if (ang > 8) begin
      ang = 16 - ang;
      neg = 1'b1;
    end
    case (ang)
      1:       mag = 7'd11;
      2:       mag = 7'd10;
      3:       mag = 7'd9;
      4:       mag = 7'd8;
      5:       mag = 7'd6;
      6:       mag = 7'd4;
      7:       mag = 7'd2;
      default: mag = 7'd0;
    endcase
    return {neg, mag};
  endfunction

  // Sign-magnitude ROM word to a signed 9-bit operand.
  function automatic logic signed [8:0] sm_value(input logic [ENTRY_W-1:0] e);
    logic signed [8:0] m;
    m = $signed({2'b00, e[6:0]});
    return e[7] ? -m : m;
  endfunction

  // Limit a scaled coefficient: DC to 0..255, AC to -127..127.
  function automatic logic [7:0] clamp_coef(input logic signed [31:0] v,
                                            input logic dc);
    if (dc) begin
      if (v < 0)        return 8'd0;
      if (v > 32'sd255) return 8'hff;
    end else begin
      if (v > 32'sd127)  return 8'h7f;
      if (v < -32'sd127) return 8'h81;
    end
    return v[7:0];
  endfunction

endpackage

// File: rtl/fdct8_tile_fetch.sv
`timescale 1ns/1ps
module fdct8_tile_fetch #(
  parameter int ADDR_W = 18,
  parameter int WID_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] origin,
  input  logic [WID_W-1:0]  pitch,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [5:0]        rd_idx,
  output logic              rd_last
);

  logic              active;
  logic [2:0]        row_q, col_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] pitch_ext;
  logic [WID_W-1:0]  pitch_q;

  assign pitch_ext = {{(ADDR_W-WID_W){1'b0}}, pitch_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      base_q  <= '0;
      pitch_q <= '0;
    end else if (go) begin
      active  <= 1'b1;
      row_q   <= '0;
      col_q   <= '0;
      base_q  <= origin;
      pitch_q <= pitch;
    end else if (active) begin
      col_q <= col_q + 3'd1;
      if (col_q == 3'd7) begin
        row_q  <= row_q + 3'd1;
        base_q <= base_q + pitch_ext;
        if (row_q == 3'd7) active <= 1'b0;
      end
    end
  end

  assign rd_en   = active;
  assign rd_addr = base_q + {{(ADDR_W-3){1'b0}}, col_q};
  assign rd_idx  = {row_q, col_q};
  assign rd_last = active && (row_q == 3'd7) && (col_q == 3'd7);

endmodule

// File: rtl/fdct8_basis_rom.sv
`timescale 1ns/1ps
module fdct8_basis_rom
  import fdct8_pkg::*;
(
  input  logic [IDX_W-1:0]   row_sel,
  input  logic [IDX_W-1:0]   col_sel,
  output logic [ENTRY_W-1:0] entry
);

  logic [ENTRY_W-1:0] table_w [TILE_SQ];

  for (genvar gi = 0; gi < TILE_N; gi++) begin : g_row
    for (genvar gj = 0; gj < TILE_N; gj++) begin : g_col
      assign table_w[gi*TILE_N + gj] = basis_entry(gi, gj);
    end
  end

  assign entry = table_w[{row_sel, col_sel}];

endmodule

// File: rtl/fdct8_mac.sv
`timescale 1ns/1ps
module fdct8_mac #(
  parameter int A_W   = 21,
  parameter int ACC_W = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    first,
  input  logic signed [A_W-1:0]   a,
  input  logic signed [8:0]       b,
  output logic        [ACC_W-1:0] acc_sum
);

  localparam int PROD_W = A_W + 9;

  logic [PROD_W-1:0] a_ext, b_ext, prod;
  logic [ACC_W-1:0]  acc_q;

  assign a_ext   = {{9{a[A_W-1]}}, a};
  assign b_ext   = {{A_W{b[8]}}, b};
  assign prod    = a_ext * b_ext;
  assign acc_sum = (first ? '0 : acc_q) + prod[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_sum;
  end

endmodule

// File: rtl/fdct8_core.sv
`timescale 1ns/1ps
module fdct8_core
  import fdct8_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int WID_W   = 12,
  parameter int SAMP_W  = 21,
  parameter int MID_W   = 18,
  parameter int ACC_W   = 26,
  parameter int FRAC_SH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] tile_origin,
  input  logic [WID_W-1:0]  img_width,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              coef_valid,
  output logic [7:0]        coef_data,
  output logic              tile_done
);

  fdct8_state_e state;

  logic [IDX_W-1:0] cu, cv, ck;
  logic             wr_pend;
  logic [5:0]       wr_idx;
  logic             coef_valid_q, coef_dc_q, done_q;
  logic [7:0]       coef_q;

  logic [SAMP_W-1:0] samp_buf [TILE_SQ];
  logic [MID_W-1:0]  mid_buf  [TILE_SQ];

  // Named internal events for the checker
  logic busy, in_pass, term_last, fetch_go, fetch_last;
  logic [5:0] fetch_idx;

  assign busy      = (state != ST_IDLE);
  assign in_pass   = (state == ST_ROWS) || (state == ST_COLS);
  assign term_last = in_pass && (ck == 3'd7);
  assign fetch_go  = (state == ST_IDLE) && start;

  fdct8_tile_fetch #(.ADDR_W(ADDR_W), .WID_W(WID_W)) fetch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (fetch_go),
    .origin  (tile_origin),
    .pitch   (img_width),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_addr),
    .rd_idx  (fetch_idx),
    .rd_last (fetch_last)
  );

  // Basis lookup: pass 1 uses T[u][k], pass 2 uses T[v][k]
  logic [IDX_W-1:0]   rom_row;
  logic [ENTRY_W-1:0] rom_entry;
  assign rom_row = (state == ST_COLS) ? cv : cu;

  fdct8_basis_rom rom_i (
    .row_sel (rom_row),
    .col_sel (ck),
    .entry   (rom_entry)
  );

  // Operand A: sample X[k][v] in pass 1, intermediate P[u][k] in pass 2
  logic signed [SAMP_W-1:0] op_a;
  logic        [MID_W-1:0]  mid_rd;
  assign mid_rd = mid_buf[{cu, ck}];
  assign op_a = (state == ST_COLS)
              ? $signed({{(SAMP_W-MID_W){mid_rd[MID_W-1]}}, mid_rd})
              : $signed(samp_buf[{ck, cv}]);

  logic [ACC_W-1:0] acc_sum;

  fdct8_mac #(.A_W(SAMP_W), .ACC_W(ACC_W)) mac_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_pass),
    .first   (ck == 3'd0),
    .a       (op_a),
    .b       (sm_value(rom_entry)),
    .acc_sum (acc_sum)
  );

  // Final normalisation and limiting
  logic signed [ACC_W-1:0] scaled;
  logic signed [31:0]      scaled32;
  assign scaled   = $signed(acc_sum) >>> FRAC_SH;
  assign scaled32 = $signed({{(32-ACC_W){scaled[ACC_W-1]}}, scaled});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cu           <= '0;
      cv           <= '0;
      ck           <= '0;
      wr_pend      <= 1'b0;
      wr_idx       <= '0;
      coef_valid_q <= 1'b0;
      coef_dc_q    <= 1'b0;
      coef_q       <= '0;
      done_q       <= 1'b0;
    end else begin
      coef_valid_q <= 1'b0;
      done_q       <= 1'b0;
      wr_pend      <= mem_rd_en;
      wr_idx       <= fetch_idx;
      case (state)
        ST_IDLE:  if (start) state <= ST_FETCH;
        ST_FETCH: if (fetch_last) state <= ST_DRAIN;
        ST_DRAIN: begin
          state <= ST_ROWS;
          cu    <= '0;
          cv    <= '0;
          ck    <= '0;
        end
        ST_ROWS, ST_COLS: begin
          ck <= ck + 3'd1;
          if (term_last) begin
            cv <= cv + 3'd1;
            if (cv == 3'd7) begin
              cu <= cu + 3'd1;
              if (cu == 3'd7) state <= (state == ST_ROWS) ? ST_COLS : ST_FIN;
            end
          end
          if (state == ST_COLS && term_last) begin
            coef_valid_q <= 1'b1;
            coef_dc_q    <= (cu == 3'd0) && (cv == 3'd0);
            coef_q       <= clamp_coef(scaled32, (cu == 3'd0) && (cv == 3'd0));
          end
        end
        ST_FIN: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_pend) samp_buf[wr_idx] <= {{(SAMP_W-8){1'b0}}, mem_rdata};
    if (state == ST_ROWS && term_last) mid_buf[{cu, cv}] <= acc_sum[MID_W-1:0];
  end

  assign coef_valid = coef_valid_q;
  assign coef_data  = coef_q;
  assign tile_done  = done_q;

endmodule

// File: rtl/fdct8_chk.sv
`timescale 1ns/1ps
module fdct8_chk #(
  parameter int ADDR_W = 18,
  parameter int WID_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] tile_origin,
  input logic [WID_W-1:0]  img_width,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              coef_valid,
  input logic [7:0]        coef_data,
  input logic              coef_dc,
  input logic              tile_done,
  input logic              busy
);

  logic [ADDR_W-1:0] prev_addr, origin_q, step_col, step_row;
  logic [WID_W-1:0]  width_q;
  logic              prev_rd;
  logic [7:0]        vcnt, rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_rd   <= 1'b0;
      origin_q  <= '0;
      width_q   <= '0;
      vcnt      <= '0;
      rcnt      <= '0;
    end else begin
      prev_addr <= mem_addr;
      prev_rd   <= mem_rd_en;
      if (start && !busy) begin
        origin_q <= tile_origin;
        width_q  <= img_width;
      end
      if (tile_done) vcnt <= '0;
      else if (coef_valid) vcnt <= vcnt + 8'd1;
      if (tile_done) rcnt <= '0;
      else if (mem_rd_en) rcnt <= rcnt + 8'd1;
    end
  end

  assign step_col = prev_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign step_row = prev_addr + {{(ADDR_W-WID_W){1'b0}}, width_q} - {{(ADDR_W-3){1'b0}}, 3'd7};

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!coef_valid && !mem_rd_en));

  // R2
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !prev_rd) |-> (mem_addr == origin_q));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && prev_rd) |-> ((mem_addr == step_col) || (mem_addr == step_row)));

  // R5
  coef_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |-> (vcnt == 8'd64 && !coef_valid));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |=> !tile_done);

  // R6
  ac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && !coef_dc) |-> (coef_data != 8'h80));

  // R7
  read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (rcnt < 8'd64));

endmodule

bind fdct8_core fdct8_chk #(.ADDR_W(ADDR_W), .WID_W(WID_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .tile_origin (tile_origin),
  .img_width   (img_width),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr),
  .coef_valid  (coef_valid),
  .coef_data   (coef_data),
  .coef_dc     (coef_dc_q),
  .tile_done   (tile_done),
  .busy        (busy)
);

// File: tb/fdct8_core_tb_top.sv
`timescale 1ns/1ps
module fdct8_core_tb_top;

  localparam int ADDR_W = 18;
  localparam int WID_W  = 12;
  localparam int IMG_W  = 32;
  localparam int IMG_H  = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] tile_origin = '0;
  logic [WID_W-1:0]  img_width = WID_W'(IMG_W);
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rdata = '0;
  logic              coef_valid;
  logic [7:0]        coef_data;
  logic              tile_done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [7:0] img [IMG_W*IMG_H];
  int exp_c [64];
  int got_c [64];

  always #4 clk = ~clk;

  fdct8_core #(.ADDR_W(ADDR_W), .WID_W(WID_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .tile_origin (tile_origin),
    .img_width   (img_width),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .coef_valid  (coef_valid),
    .coef_data   (coef_data),
    .tile_done   (tile_done)
  );

  // Byte memory with one cycle of read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= img[int'(mem_addr) % (IMG_W*IMG_H)];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int basis_ref(input int u, input int j);
    real c, v;
    c = (u == 0) ? $sqrt(1.0 / 8.0) : 0.5;
    v = 8.0 * $sqrt(8.0) * c * $cos(real'((2 * j + 1) * u) * 3.14159265358979 / 16.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  task automatic model_tile(input int r0, input int c0);
    int p [8][8];
    for (int u = 0; u < 8; u++)
      for (int j = 0; j < 8; j++) begin
        p[u][j] = 0;
        for (int k = 0; k < 8; k++)
          p[u][j] += basis_ref(u, k) * int'(img[(r0 + k) * IMG_W + c0 + j]);
      end
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        int s;
        s = 0;
        for (int j = 0; j < 8; j++) s += p[u][j] * basis_ref(v, j);
        s = s >>> 12;
        if (u == 0 && v == 0) s = (s < 0) ? 0 : (s > 255 ? 255 : s);
        else s = (s < -127) ? -127 : (s > 127 ? 127 : s);
        exp_c[u*8+v] = s;
      end
  endtask

  // Runs a tile, checking addresses (R2), stream count and done timing (R5);
  // optional extra start pulses during the run (R7).
  task automatic run_tile(input int r0, input int c0, input bit inject, input string req);
    int reads, outs, cyc, last_v, done_at, done_cnt;
    bit addr_ok;
    reads = 0; outs = 0; cyc = 0; last_v = -1; done_at = -1; done_cnt = 0; addr_ok = 1'b1;
    @(negedge clk);
    tile_origin = ADDR_W'(r0 * IMG_W + c0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tile_origin = '0;
    while (cyc < 3000 && done_at < 0) begin
      if (inject && (cyc == 10 || cyc == 300)) start = 1'b1;
      else start = 1'b0;
      if (mem_rd_en) begin
        if (int'(mem_addr) != (r0 + reads / 8) * IMG_W + c0 + reads % 8) begin
          if (addr_ok)
            check(1'b0, "R2", "read address", int'(mem_addr),
                  (r0 + reads / 8) * IMG_W + c0 + reads % 8);
          addr_ok = 1'b0;
        end
        reads++;
      end
      if (coef_valid) begin
        if (outs < 64) got_c[outs] = (outs == 0) ? int'(coef_data) : int'($signed(coef_data));
        outs++;
        last_v = cyc;
      end
      if (tile_done) begin
        done_at = cyc;
        done_cnt++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(addr_ok, "R2", "address sequence ok", int'(addr_ok), 1);
    check(reads == 64, req, "read count", reads, 64);
    check(outs == 64, "R5", "coefficient count", outs, 64);
    check(done_at == last_v + 1, "R5", "done one cycle after last coef", done_at, last_v + 1);
    check(!tile_done, "R5", "done is a single pulse", int'(tile_done), 0);
    model_tile(r0, c0);
    for (int m = 0; m < 64; m++)
      if (got_c[m] != exp_c[m]) check(1'b0, "R3", $sformatf("coef %0d", m), got_c[m], exp_c[m]);
    check(1'b1, "R3", "coefficient stream compared", 0, 0);
  endtask

  task automatic t_reset;
    // R1
    check(!coef_valid, "R1", "coef_valid after reset", int'(coef_valid), 0);
    check(!tile_done, "R1", "tile_done after reset", int'(tile_done), 0);
    check(!mem_rd_en, "R1", "mem_rd_en after reset", int'(mem_rd_en), 0);
  endtask

  task automatic t_flat(input int val, input int r0, input int c0, input string req);
    for (int i = 0; i < IMG_W*IMG_H; i++) img[i] = 8'(val);
    run_tile(r0, c0, 1'b0, "R2");
    // R4 / R9: flat tile
    check(got_c[0] == val, req, "flat DC", got_c[0], val);
    for (int m = 1; m < 64; m++)
      if (got_c[m] != 0) check(1'b0, "R4", $sformatf("flat AC %0d", m), got_c[m], 0);
    check(1'b1, "R4", "flat AC scan", 0, 0);
  endtask

  task automatic t_texture;
    bit neg_frac;
    for (int y = 0; y < IMG_H; y++)
      for (int x = 0; x < IMG_W; x++)
        img[y*IMG_W+x] = 8'((x * 37 + y * 91 + x * y * 3 + (x ^ y) * 11) & 255);
    run_tile(5, 9, 1'b0, "R2");
    // R8: at least one coefficient must come from a floored negative sum
    neg_frac = 1'b0;
    for (int m = 1; m < 64; m++) if (exp_c[m] < 0) neg_frac = 1'b1;
    check(neg_frac, "R8", "negative coefficients present", int'(neg_frac), 1);
  endtask

  task automatic t_edge;
    // R6: vertical step edge pushes coefficient (0,1) toward the AC bound
    for (int y = 0; y < IMG_H; y++)
      for (int x = 0; x < IMG_W; x++)
        img[y*IMG_W+x] = (x % 8 < 4) ? 8'd255 : 8'd0;
    run_tile(8, 16, 1'b0, "R2");
    check(got_c[1] >= 100 && got_c[1] <= 127, "R6", "edge AC(0,1) near bound", got_c[1], exp_c[1]);
    for (int m = 1; m < 64; m++)
      if (got_c[m] < -127 || got_c[m] > 127)
        check(1'b0, "R6", $sformatf("AC range %0d", m), got_c[m], 127);
    check(1'b1, "R6", "AC range scan", 0, 0);
  endtask

  task automatic t_restart_ignored;
    // R7: extra start pulses during fetch and arithmetic are ignored
    for (int y = 0; y < IMG_H; y++)
      for (int x = 0; x < IMG_W; x++)
        img[y*IMG_W+x] = 8'((x * 19 + y * y * 5) & 255);
    run_tile(16, 24, 1'b1, "R7");
    repeat (4) @(negedge clk);
    check(!mem_rd_en && !coef_valid, "R7", "idle after run with injected starts",
          int'(mem_rd_en || coef_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat(100, 0, 0, "R4");
    t_flat(255, 8, 8, "R9");
    t_texture();
    t_edge();
    t_restart_ignored();
    t_flat(0, 16, 0, "R4");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule